// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register

This block is the digital front end of a serial-input voltage DAC. A host sends 16-bit words over a three-wire link made of a serial clock, an active-low frame select and a data line. The block shifts the words into an input register and moves the received code into a 14-bit code register. The move happens either at the end of the frame or on the falling edge of an active-low load strobe. The code register drives a parallel bus towards the converter. A clear input forces the bus to the mid-scale code, which is 0 V in bipolar operation. A power-down input switches the output stage off and leaves every register intact.

A single serial output is shared by two functions. While the readback enable is high, it shifts out the code register, padded with leading zeros to 16 bits. While the enable is low, it passes on the bits that fall out of the input register, so several devices can share one data path in a chain. All serial pins are sampled by the system clock `clk`. They must be synchronous to it and change no faster than once every two clock cycles.

Top module: `sdac_serial_if`

## Requirements
- R1: Words are shifted in MSB first. `ser_din` is taken on each high-to-low transition of `ser_clk` while `ser_sel_n` is low. The DAC code is bits [13:0] of the word, and bits [15:14] are ignored.
- R2: A frame is accepted when `ser_sel_n` rises after at least 16 bits. The last 16 bits form the word. The bits may arrive in separate bursts, with `ser_sel_n` held low between them.
- R3: A frame of fewer than 16 bits is discarded. Neither the code register nor the held word changes, so a later load strobe still delivers the last complete word.
- R4: If `load_n` is low when a frame is accepted, `dac_code` takes the new code one clock later.
- R5: If `load_n` is high when a frame is accepted, the word is only held. A later high-to-low transition of `load_n` copies the held code into `dac_code`.
- R6: A rising edge on `rb_en` captures {2'b00, dac_code} for readback. While `rb_en` is high, `ser_dout` shows the MSB of the captured word. Each falling `ser_clk` edge advances it by one bit, so the word comes out MSB first.
- R7: While `rb_en` is low, `ser_dout` changes on each accepted falling `ser_clk` edge to the bit shifted out of the MSB of the input register. This is the input stream delayed by 16 bits.
- R8: While `clear` is high, `dac_code` is 14'h2000. Clear takes priority over a frame update and over a load strobe in the same cycle.
- R9: One clock after `pwr_down` goes high, `out_on` goes low, and `dac_code` keeps its value. `out_on` returns high one clock after `pwr_down` falls.
- R10: After reset, `dac_code` is 14'h2000, `out_on` is 1 and `ser_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on falling edges |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Load strobe; low means automatic update, a falling edge copies the held word |
| rb_en | input | 1 | Readback enable for `ser_dout` |
| clear | input | 1 | Forces the code to mid-scale |
| pwr_down | input | 1 | Low-power request for the output stage |
| ser_dout | output | 1 | Readback bit or chain pass-through bit |
| dac_code | output | 14 | Code register towards the converter |
| out_on | output | 1 | Output stage enabled |

## Verification
The hardest case to reach is a discarded frame that still changes nothing. A short frame never touches `dac_code`, so watching the bus alone proves little. The bench first leaves a complete word held, with `load_n` high, so the bus does not move. It then sends a 10-bit frame and fires the load strobe. If the short frame had overwritten the held word, the bus would show the wrong code. The 16-bit delay of the chain path is checked with a 32-bit frame, comparing `ser_dout` on the second 16 edges against the first word.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_CLEAR  = 2'd1,
      UPD_FRAME  = 2'd2,
      UPD_STROBE = 2'd3
   } upd_src_e;

   function automatic int mid_code(input int w);
      return 1 << (w - 1);
   endfunction
endpackage

// File: rtl/sdac_shift_in.sv
module sdac_shift_in #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_fall,
   input  logic              sel_low,
   input  logic              sel_rise,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              frame_ok,
   output logic              chain_bit
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cnt_q     <= '0;
         chain_bit <= 1'b0;
      end else if (sel_low && sclk_fall) begin
         sh_q      <= {sh_q[WORD_W-2:0], din};
         chain_bit <= sh_q[WORD_W-1];
         if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end else if (!sel_low) begin
         cnt_q <= '0;
      end
   end

   assign word     = sh_q;
   assign frame_ok = sel_rise && (cnt_q == FULL);

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
endmodule

// File: rtl/sdac_code_reg.sv
module sdac_code_reg
   import sdac_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_ok,
   input  logic [WORD_W-1:0] word,
   input  logic              load_n,
   input  logic              load_fall,
   input  logic              clear,
   input  logic              pwr_down,
   output logic [CODE_W-1:0] code,
   output logic              out_on
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   logic [CODE_W-1:0] held_q;
   upd_src_e          src;

   always_comb begin
      if (clear)                    src = UPD_CLEAR;
      else if (frame_ok && !load_n) src = UPD_FRAME;
      else if (load_fall)           src = UPD_STROBE;
      else                          src = UPD_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= MID;
         held_q <= MID;
         out_on <= 1'b1;
      end else begin
         out_on <= !pwr_down;
         if (frame_ok) held_q <= word[CODE_W-1:0];
         case (src)
            UPD_CLEAR:  code <= MID;
            UPD_FRAME:  code <= word[CODE_W-1:0];
            UPD_STROBE: code <= held_q;
            default:    code <= code;
         endcase
      end
   end

   // R8
   clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> code == MID);
   // R4
   auto_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && !load_n && !clear) |=> code == $past(word[CODE_W-1:0]));
   // R9
   pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down && !clear && !frame_ok && !load_fall) |=> (!out_on && $stable(code)));
endmodule

// File: rtl/sdac_readback.sv
module sdac_readback #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rb_en,
   input  logic              rb_rise,
   input  logic              sclk_fall,
   input  logic [CODE_W-1:0] code,
   input  logic              chain_bit,
   output logic              sdo
);
   localparam int PAD = WORD_W - CODE_W;

   logic [WORD_W-1:0] img;
   logic [WORD_W-1:0] rb_q;

   generate
      if (PAD > 0) begin : g_pad
         assign img = {{PAD{1'b0}}, code};
         // R6
         rb_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rb_rise |=> rb_q[WORD_W-1 -: PAD] == '0);
      end else begin : g_nopad
         assign img = code;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rb_q <= '0;
      else if (rb_rise)            rb_q <= img;
      else if (rb_en && sclk_fall) rb_q <= {rb_q[WORD_W-2:0], 1'b0};
   end

   assign sdo = rb_en ? rb_q[WORD_W-1] : chain_bit;
endmodule

// File: rtl/sdac_serial_if.sv
module sdac_serial_if #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_sel_n,
   input  logic              ser_din,
   input  logic              load_n,
   input  logic              rb_en,
   input  logic              clear,
   input  logic              pwr_down,
   output logic              ser_dout,
   output logic [CODE_W-1:0] dac_code,
   output logic              out_on
);
   generate
      if (CODE_W > WORD_W || CODE_W < 2 || WORD_W < 2) begin : g_bad_cfg
         $error("sdac_serial_if: CODE_W must lie in 2..WORD_W");
      end
   endgenerate

   logic sclk_q, sel_q, load_q, rb_q;
   logic sclk_fall, sel_rise, load_fall, rb_rise;
   logic [WORD_W-1:0] word;
   logic frame_ok, chain_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         sel_q  <= 1'b1;
         load_q <= 1'b1;
         rb_q   <= 1'b0;
      end else begin
         sclk_q <= ser_clk;
         sel_q  <= ser_sel_n;
         load_q <= load_n;
         rb_q   <= rb_en;
      end
   end

   assign sclk_fall = sclk_q & ~ser_clk;
   assign sel_rise  = ~sel_q & ser_sel_n;
   assign load_fall = load_q & ~load_n;
   assign rb_rise   = ~rb_q & rb_en;

   sdac_shift_in #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .sel_low(~ser_sel_n),
      .sel_rise(sel_rise), .din(ser_din), .word(word), .frame_ok(frame_ok),
      .chain_bit(chain_bit));

   sdac_code_reg #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_code (
      .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .word(word),
      .load_n(load_n), .load_fall(load_fall), .clear(clear),
      .pwr_down(pwr_down), .code(dac_code), .out_on(out_on));

   sdac_readback #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_rb (
      .clk(clk), .rst_n(rst_n), .rb_en(rb_en), .rb_rise(rb_rise),
      .sclk_fall(sclk_fall), .code(dac_code), .chain_bit(chain_bit),
      .sdo(ser_dout));

   // R3
   short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && !frame_ok && !clear && !load_fall) |=> $stable(dac_code));
endmodule

// File: tb/sdac_serial_if_bench.sv
module sdac_serial_if_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b1, ser_sel_n = 1'b1, ser_din = 1'b0;
   logic load_n = 1'b1, rb_en = 1'b0, clear = 1'b0, pwr_down = 1'b0;
   logic ser_dout, out_on;
   logic [13:0] dac_code;
   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   sdac_serial_if u_sdac_serial_if (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
      .ser_din(ser_din), .load_n(load_n), .rb_en(rb_en), .clear(clear),
      .pwr_down(pwr_down), .ser_dout(ser_dout), .dac_code(dac_code),
      .out_on(out_on));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      ser_din = b;
      tick(1);
      ser_clk = 1'b0;
      tick(2);
      ser_clk = 1'b1;
      tick(1);
   endtask

   task automatic send(input logic [31:0] w, input int n);
      ser_sel_n = 1'b0;
      tick(2);
      for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
   endtask

   task automatic end_frame();
      ser_sel_n = 1'b1;
      tick(2);
   endtask

   task automatic t_reset();
      chk("R10 code", {2'b0, dac_code}, 16'h2000);
      chk("R10 out_on", {15'b0, out_on}, 16'h1);
      chk("R10 sdo", {15'b0, ser_dout}, 16'h0);
   endtask

   task automatic t_auto();
      load_n = 1'b0;
      tick(2);
      send(32'h0000_C123, 16);
      chk("R4 before frame end", {2'b0, dac_code}, 16'h2000);
      end_frame();
      chk("R1/R4 auto update, top bits ignored", {2'b0, dac_code}, 16'h0123);
   endtask

   task automatic t_burst();
      send(32'h0000_3A, 8);
      tick(20);
      for (int i = 7; i >= 0; i--) put_bit(8'h5C >> i);
      end_frame();
      chk("R2 two bursts", {2'b0, dac_code}, 16'h3A5C);
   endtask

   task automatic t_strobe_and_short();
      load_n = 1'b1;
      tick(2);
      send(32'h0000_1111, 16);
      end_frame();
      chk("R5 held, not applied", {2'b0, dac_code}, 16'h3A5C);
      send(32'h0000_02AB, 10);
      end_frame();
      chk("R3 short frame no change", {2'b0, dac_code}, 16'h3A5C);
      load_n = 1'b0;
      tick(2);
      chk("R5 strobe applies held word", {2'b0, dac_code}, 16'h1111);
      chk("R3 short frame did not replace held word", {2'b0, dac_code}, 16'h1111);
      load_n = 1'b1;
      tick(2);
   endtask

   task automatic t_daisy();
      logic [15:0] a = 16'hB6D3;
      logic [15:0] b = 16'h0F4E;
      logic [31:0] w = {a, b};
      int bad = 0;
      load_n = 1'b0;
      tick(2);
      ser_sel_n = 1'b0;
      tick(2);
      for (int k = 0; k < 32; k++) begin
         put_bit(w[31-k]);
         if (k >= 16 && ser_dout !== a[31-k]) bad++;
      end
      chk("R7 chain output matches first word", 16'(bad), 16'h0);
      end_frame();
      chk("R2 long frame keeps last 16 bits", {2'b0, dac_code}, {2'b0, b[13:0]});
   endtask

   task automatic t_readback();
      logic [15:0] img = {2'b00, dac_code};
      int bad = 0;
      rb_en = 1'b1;
      tick(2);
      for (int i = 0; i < 16; i++) begin
         if (ser_dout !== img[15-i]) bad++;
         ser_clk = 1'b0;
         tick(2);
         ser_clk = 1'b1;
         tick(1);
      end
      chk("R6 readback bit errors", 16'(bad), 16'h0);
      chk("R6 readback leaves code", {2'b0, dac_code}, img);
      rb_en = 1'b0;
      tick(2);
   endtask

   task automatic t_clear();
      clear = 1'b1;
      tick(1);
      chk("R8 clear to mid", {2'b0, dac_code}, 16'h2000);
      send(32'h0000_0777, 16);
      end_frame();
      chk("R8 clear beats frame update", {2'b0, dac_code}, 16'h2000);
      clear = 1'b0;
      tick(1);
   endtask

   task automatic t_power();
      send(32'h0000_1234, 16);
      end_frame();
      pwr_down = 1'b1;
      tick(1);
      chk("R9 out_on low", {15'b0, out_on}, 16'h0);
      chk("R9 code kept", {2'b0, dac_code}, 16'h1234);
      pwr_down = 1'b0;
      tick(1);
      chk("R9 out_on restored", {15'b0, out_on}, 16'h1);
      chk("R9 code after restore", {2'b0, dac_code}, 16'h1234);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_auto();
      t_burst();
      t_strobe_and_short();
      t_daisy();
      t_readback();
      t_clear();
      t_power();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule